// File: doc/BRIEF.md
# Delayed Transaction Error Monitor

This block watches the delayed transactions that a bridge forwards downstream, and it records when one of them is given up. For the single pending read request it counts target retries, and it does the same for the single pending write request. When a request reaches the retry limit of 2^RETRY_W retries, the block drops it and strobes a discard output for that request type. A separate pulse reports that the master timeout expired while a completion was still queued. That pulse is recorded as a third error condition.

Each of the three conditions sets a sticky status bit. Software clears a status bit by writing 1 to it. A condition can also raise the system error line for one cycle. This happens only when the global error enable is set and the condition's own disable bit is clear. The execution of the bus transactions themselves is outside this block. The inputs are single-cycle event pulses from the bridge's queues and retry logic.

Top module: `dtx_err_mon`

## Requirements
- R1: While reset is asserted and after it is released, `status` is 000, `serr` is 0, and both discard strobes are 0.
- R2: A read request is pending from an `rd_req` pulse until it completes or is discarded. While it is pending and `retry_cnt_en` is 1, the 2^RETRY_W-th `rd_retry` causes two results one cycle later: `rd_discard` pulses and status bit 1 becomes set. Fewer retries cause neither result.
- R3: The same rule holds for writes, with `wr_req`, `wr_retry`, `wr_discard` and status bit 2.
- R4: An `mto_expire` pulse sets status bit 0 one cycle later.
- R5: The retry count restarts at zero in three cases: a new request, a completion (`rd_done`/`wr_done`), or a discard. Retries that arrive while no request of that type is pending are ignored.
- R6: While `retry_cnt_en` is 0, retries are not counted and no discard occurs.
- R7: A cycle with `clr_wr` high clears every status bit whose `clr_data` bit is 1. Bits written with 0 are unchanged, and without `clr_wr` a set bit stays set. The bit positions are 0 for timeout, 1 for read, and 2 for write.
- R8: If a condition's event and a clear of its bit fall in the same cycle, the bit ends up set.
- R9: `serr` pulses one cycle after an event only if three things hold: `err_en` is 1, the condition's `err_dis` bit (same positions as status) is 0, and its status bit was clear before the event. Otherwise `serr` stays 0.
- R10: The discard strobes and `serr` each last one cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| retry_cnt_en | input | 1 | Enables retry counting and retry-based discard |
| err_en | input | 1 | Global system error enable |
| err_dis | input | 3 | Per-condition error disable mask |
| rd_req | input | 1 | New delayed read request accepted |
| rd_retry | input | 1 | Target retry seen for the read request |
| rd_done | input | 1 | Read request completed |
| wr_req | input | 1 | New delayed write request accepted |
| wr_retry | input | 1 | Target retry seen for the write request |
| wr_done | input | 1 | Write request completed |
| mto_expire | input | 1 | Master timeout discarded a queued completion |
| clr_wr | input | 1 | Status write strobe |
| clr_data | input | 3 | Write-one-to-clear data |
| rd_discard | output | 1 | Read request discarded (one-cycle strobe) |
| wr_discard | output | 1 | Write request discarded (one-cycle strobe) |
| status | output | 3 | Sticky error status |
| serr | output | 1 | System error pulse |

## Verification
Every result is due exactly one clock edge after its cause. A discard strobe, the matching status bit and the `serr` pulse are all visible after the edge that takes the terminal retry. A timeout sets its status bit, and a clear takes effect, after the edge on which the pulse or the write is presented. The bench drives inputs on the falling edge and samples outputs on the next falling edge, which lies after exactly one rising edge. It counts strobes cycle by cycle over sweeps of retry counts, clear masks, and enable/disable combinations, using a three-bit counter so that the limit is 8.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  localparam int unsigned NUM_COND = 3;
  localparam int unsigned NUM_CHAN = 2;
  // condition positions: timeout, read discard, write discard
  localparam int unsigned COND_MTO = 0;
  localparam int unsigned COND_RD  = 1;
  localparam int unsigned COND_WR  = 2;
  typedef logic [NUM_COND-1:0] cond_vec_t;
endpackage

// File: rtl/dtx_retry_track.sv
module dtx_retry_track #(
  parameter int unsigned CNT_W = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cnt_en,
  input  logic req,
  input  logic done,
  input  logic retry,
  output logic term,
  output logic discard
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic             act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             disc_q;
  logic             upd;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    term  = 1'b0;
    if (req) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (done) begin
      act_d = 1'b0;
      cnt_d = '0;
    end else if (act_q && retry && cnt_en) begin
      if (cnt_q == CNT_MAX) begin
        term  = 1'b1;
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  assign upd = req | done | (act_q & retry & cnt_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (upd) begin
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) disc_q <= 1'b0;
    else        disc_q <= term;
  end

  assign discard = disc_q;
endmodule

// File: rtl/dtx_status_w1c.sv
module dtx_status_w1c
  import dtx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cond_vec_t ev,
  input  logic      clr_wr,
  input  cond_vec_t clr_data,
  input  logic      err_en,
  input  cond_vec_t err_dis,
  output cond_vec_t status,
  output logic      serr
);
  cond_vec_t st_q;
  cond_vec_t st_d;
  cond_vec_t clr_mask;
  cond_vec_t fresh;
  logic      serr_q, serr_d;

  always_comb begin
    clr_mask = clr_wr ? clr_data : '0;
    st_d     = (st_q & ~clr_mask) | ev;
    fresh    = ev & ~st_q & ~err_dis;
    serr_d   = err_en & (|fresh);
  end

  for (genvar i = 0; i < NUM_COND; i++) begin : g_bit
    logic bit_en;
    assign bit_en = ev[i] | clr_mask[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      st_q[i] <= 1'b0;
      else if (bit_en) st_q[i] <= st_d[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serr_q <= 1'b0;
    else        serr_q <= serr_d;
  end

  assign status = st_q;
  assign serr   = serr_q;
endmodule

// File: rtl/dtx_err_mon.sv
module dtx_err_mon
  import dtx_pkg::*;
#(
  parameter int unsigned RETRY_W = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       retry_cnt_en,
  input  logic       err_en,
  input  logic [2:0] err_dis,
  input  logic       rd_req,
  input  logic       rd_retry,
  input  logic       rd_done,
  input  logic       wr_req,
  input  logic       wr_retry,
  input  logic       wr_done,
  input  logic       mto_expire,
  input  logic       clr_wr,
  input  logic [2:0] clr_data,
  output logic       rd_discard,
  output logic       wr_discard,
  output logic [2:0] status,
  output logic       serr
);
  logic [NUM_CHAN-1:0] req_v, done_v, retry_v, term_v, disc_v;
  cond_vec_t           ev;

  assign req_v   = {wr_req,   rd_req};
  assign done_v  = {wr_done,  rd_done};
  assign retry_v = {wr_retry, rd_retry};

  for (genvar ch = 0; ch < NUM_CHAN; ch++) begin : g_chan
    dtx_retry_track #(.CNT_W(RETRY_W)) u_trk (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_en  (retry_cnt_en),
      .req     (req_v[ch]),
      .done    (done_v[ch]),
      .retry   (retry_v[ch]),
      .term    (term_v[ch]),
      .discard (disc_v[ch])
    );
  end

  always_comb begin
    ev           = '0;
    ev[COND_MTO] = mto_expire;
    ev[COND_RD]  = term_v[0];
    ev[COND_WR]  = term_v[1];
  end

  dtx_status_w1c u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev),
    .clr_wr   (clr_wr),
    .clr_data (clr_data),
    .err_en   (err_en),
    .err_dis  (err_dis),
    .status   (status),
    .serr     (serr)
  );

  assign rd_discard = disc_v[0];
  assign wr_discard = disc_v[1];
endmodule

// File: rtl/dtx_err_mon_chk.sv
module dtx_err_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       retry_cnt_en,
  input logic       err_en,
  input logic       mto_expire,
  input logic       clr_wr,
  input logic [2:0] clr_data,
  input logic       rd_discard,
  input logic       wr_discard,
  input logic [2:0] status,
  input logic       serr
);
  assert_rd_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_discard |-> status[1]);
  assert_wr_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_discard |-> status[2]);
  assert_mto_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mto_expire |=> status[0]);
  assert_no_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !retry_cnt_en |=> !(rd_discard || wr_discard));
  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((status & $past(status)) == $past(status)));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mto_expire && clr_wr && clr_data[0]) |=> status[0]);
  assert_serr_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !err_en |=> !serr);
  assert_rd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_discard |=> !rd_discard);
  assert_wr_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_discard |=> !wr_discard);
endmodule

bind dtx_err_mon dtx_err_mon_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .retry_cnt_en (retry_cnt_en),
  .err_en       (err_en),
  .mto_expire   (mto_expire),
  .clr_wr       (clr_wr),
  .clr_data     (clr_data),
  .rd_discard   (rd_discard),
  .wr_discard   (wr_discard),
  .status       (status),
  .serr         (serr)
);

// File: tb/sim_dtx_err_mon.sv
module sim_dtx_err_mon;
  localparam int unsigned W   = 3;
  localparam int          LIM = 1 << W;

  logic clk = 1'b0;
  logic rst_n, retry_cnt_en, err_en, rd_req, rd_retry, rd_done;
  logic wr_req, wr_retry, wr_done, mto_expire, clr_wr;
  logic [2:0] err_dis, clr_data, status;
  logic rd_discard, wr_discard, serr;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  dtx_err_mon #(.RETRY_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .retry_cnt_en(retry_cnt_en), .err_en(err_en),
    .err_dis(err_dis), .rd_req(rd_req), .rd_retry(rd_retry), .rd_done(rd_done),
    .wr_req(wr_req), .wr_retry(wr_retry), .wr_done(wr_done),
    .mto_expire(mto_expire), .clr_wr(clr_wr), .clr_data(clr_data),
    .rd_discard(rd_discard), .wr_discard(wr_discard), .status(status), .serr(serr)
  );

  task automatic chk(input string rq, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_all();
    clr_wr = 1'b1; clr_data = 3'b111; step(); clr_wr = 1'b0; clr_data = 3'b000;
  endtask

  task automatic set_req(input int ch, input logic v);
    if (ch == 0) rd_req = v; else wr_req = v;
  endtask
  task automatic set_retry(input int ch, input logic v);
    if (ch == 0) rd_retry = v; else wr_retry = v;
  endtask
  task automatic set_done(input int ch, input logic v);
    if (ch == 0) rd_done = v; else wr_done = v;
  endtask
  function automatic logic disc_of(input int ch);
    return (ch == 0) ? rd_discard : wr_discard;
  endfunction

  // new request, n retries, one idle cycle; counts strobes
  task automatic run_chan(input int ch, input int n, output int nd, output int ns);
    nd = 0; ns = 0;
    set_req(ch, 1'b1); step(); set_req(ch, 1'b0);
    for (int i = 0; i < n; i++) begin
      set_retry(ch, 1'b1); step();
      nd += int'(disc_of(ch)); ns += int'(serr);
    end
    set_retry(ch, 1'b0); step();
    nd += int'(disc_of(ch)); ns += int'(serr);
  endtask

  task automatic retries(input int ch, input int n, output int nd);
    nd = 0;
    for (int i = 0; i < n; i++) begin
      set_retry(ch, 1'b1); step(); nd += int'(disc_of(ch));
    end
    set_retry(ch, 1'b0);
  endtask

  initial begin
    int nd, ns, tmp;
    rst_n = 1'b0; retry_cnt_en = 1'b1; err_en = 1'b1; err_dis = 3'b000;
    rd_req = 0; rd_retry = 0; rd_done = 0; wr_req = 0; wr_retry = 0; wr_done = 0;
    mto_expire = 0; clr_wr = 0; clr_data = 3'b000;
    repeat (3) step();
    chk("R1 status in reset", int'(status), 0);
    chk("R1 serr in reset", int'(serr), 0);
    rst_n = 1'b1; step();
    chk("R1 outputs after reset", int'({rd_discard, wr_discard, serr, status}), 0);

    // R2 / R3 / R10: sweep retry counts on both channels
    for (int ch = 0; ch < 2; ch++) begin
      for (int n = 1; n <= LIM + 2; n++) begin
        run_chan(ch, n, nd, ns);
        chk(ch == 0 ? "R2 read discard count" : "R3 write discard count", nd, (n >= LIM) ? 1 : 0);
        chk(ch == 0 ? "R2 read status" : "R3 write status",
            int'(status[ch+1]), (n >= LIM) ? 1 : 0);
        chk("R10 serr pulses per event", ns, (n >= LIM) ? 1 : 0);
        clear_all();
      end
    end

    // R6: counting disabled
    retry_cnt_en = 1'b0;
    for (int ch = 0; ch < 2; ch++) begin
      run_chan(ch, LIM + 3, nd, ns);
      chk("R6 no discard while counting disabled", nd, 0);
      chk("R6 status untouched", int'(status), 0);
      set_done(ch, 1'b1); step(); set_done(ch, 1'b0);
    end
    retry_cnt_en = 1'b1;

    // R5: restart on request and completion, retries when idle ignored
    for (int ch = 0; ch < 2; ch++) begin
      set_req(ch, 1'b1); step(); set_req(ch, 1'b0);
      retries(ch, LIM - 1, nd);
      set_req(ch, 1'b1); step(); set_req(ch, 1'b0);
      retries(ch, LIM - 1, tmp); nd += tmp;
      chk("R5 new request restarts count", nd, 0);
      set_done(ch, 1'b1); step(); set_done(ch, 1'b0);
      retries(ch, LIM + 2, nd);
      chk("R5 retries ignored when idle", nd, 0);
      set_req(ch, 1'b1); step(); set_req(ch, 1'b0);
      retries(ch, LIM - 1, nd);
      chk("R5 below limit after restart", nd, 0);
      retries(ch, 1, nd);
      chk("R5 limit reached after restart", nd, 1);
      retries(ch, LIM + 1, nd);
      chk("R5 idle after discard", nd, 0);
      clear_all();
    end

    // R4: timeout sets bit 0
    mto_expire = 1'b1; step(); mto_expire = 1'b0;
    chk("R4 timeout status", int'(status), 1);
    clear_all();

    // R7: sweep clear masks with all bits set
    for (int m = 0; m < 8; m++) begin
      run_chan(0, LIM, nd, ns);
      run_chan(1, LIM, nd, ns);
      mto_expire = 1'b1; step(); mto_expire = 1'b0;
      chk("R7 all bits set", int'(status), 7);
      step();
      chk("R7 sticky without write", int'(status), 7);
      clr_wr = 1'b1; clr_data = 3'(m); step(); clr_wr = 1'b0; clr_data = 3'b000;
      chk("R7 clear mask", int'(status), 7 & ~m);
      clr_wr = 1'b1; clr_data = 3'b000; step(); clr_wr = 1'b0;
      chk("R7 write of zero", int'(status), 7 & ~m);
      clear_all();
    end

    // R8: set wins against clear in the same cycle
    mto_expire = 1'b1; clr_wr = 1'b1; clr_data = 3'b111; step();
    mto_expire = 1'b0; clr_wr = 1'b0; clr_data = 3'b000;
    chk("R8 set wins over clear", int'(status), 1);
    clear_all();

    // R9: sweep enable and disable mask over all conditions
    for (int en = 0; en < 2; en++) begin
      for (int d = 0; d < 8; d++) begin
        err_en = en[0]; err_dis = 3'(d);
        mto_expire = 1'b1; step(); mto_expire = 1'b0;
        chk("R9 serr on timeout", int'(serr), (en == 1 && d[0] == 0) ? 1 : 0);
        step();
        chk("R10 serr single cycle", int'(serr), 0);
        mto_expire = 1'b1; step(); mto_expire = 1'b0;
        chk("R9 no serr when bit already set", int'(serr), 0);
        for (int ch = 0; ch < 2; ch++) begin
          run_chan(ch, LIM, nd, ns);
          chk("R9 serr on discard", ns, (en == 1 && d[ch+1] == 0) ? 1 : 0);
        end
        clear_all();
      end
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule